// File: doc/BRIEF.md
# Eight-bit ALU with Flag Register and Branch Condition Evaluator

This block is the arithmetic core of a small 8-bit processor. A 2-bit group and a 2-bit operation pick one of four arithmetic and shift functions or one of three bitwise functions. An immediate-mode bit swaps the second operand for a 4-bit constant carried in the instruction. The result and the next zero, carry, negative and overflow flags are produced combinationally in the same cycle the operands arrive.

A four-entry flag register captures the next flags on any clock edge where the core asserts its flag-write strobe. Any group that is not arithmetic or logic passes the second operand straight through, which is how a register or constant move reaches the flags. A condition evaluator compares a 4-bit condition code against the stored flags. Its condition-met output tells the core whether a branch is taken.

Top module: `alu_flags_unit`

## Requirements
- R1: With group 10, op 00/01/10/11 selects add, subtract, shift left and shift right of operand A by the second operand.
- R2: With group 11, op 00/01/10 selects AND, OR and XOR of operand A with the second operand. Op 11 yields result 0 with Z=1 and C=V=0.
- R3: In group 10 with immediate mode set, the second operand is the 4-bit constant zero-extended, and operand B is ignored.
- R4: In group 11 with immediate mode set, the second operand is a one-hot mask with bit k set for a constant value k. A constant of 8 or more gives an all-zero mask.
- R5: Groups 00 and 01 pass operand B to the result, set Z and N from it, and clear C and V.
- R6: Z is 1 exactly when the 8-bit result is zero, and N equals result bit 7, for every operation.
- R7: For add, C is the carry out of bit 7. For subtract, C=1 means no borrow (A >= B, unsigned). V is two's-complement overflow for both.
- R8: Shifts are logical and use the whole 8-bit amount. An amount of 8 or more gives 0. C is the last bit shifted out, or 0 for an amount of 0.
- R9: V is 0 for every operation other than add and subtract. C is 0 for the bitwise operations.
- R10: The flag register clears on reset. It loads the next flags on a clock edge with the flag-write strobe high, and holds its value otherwise.
- R11: Condition codes 0000 always, 0001 Z set, 0010 Z clear, 0011 C set and 0100 C clear are evaluated against the stored flags.
- R12: Condition 0101 is true when stored N differs from stored V. Condition 0110 is true when they are equal.
- R13: Condition codes 0111 through 1111 always evaluate as false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| grp | input | 2 | Instruction group (10 arithmetic/shift, 11 bitwise, else move) |
| op | input | 2 | Operation within the group |
| immMode | input | 1 | Use the 4-bit constant in place of operand B |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| imm | input | 4 | Instruction constant |
| flagWe | input | 1 | Load the next flags into the flag register |
| cond | input | 4 | Condition code to evaluate |
| result | output | 8 | ALU result |
| nextZ | output | 1 | Zero flag of the current result |
| nextC | output | 1 | Carry flag of the current result |
| nextN | output | 1 | Negative flag of the current result |
| nextV | output | 1 | Overflow flag of the current result |
| flagZ | output | 1 | Stored zero flag |
| flagC | output | 1 | Stored carry flag |
| flagN | output | 1 | Stored negative flag |
| flagV | output | 1 | Stored overflow flag |
| condMet | output | 1 | Condition code satisfied by the stored flags |

## Verification
The hardest state to reach is a stored flag set where N and V disagree in each direction. Only that state separates the two signed conditions from plain tests of N. The bench reaches it by loading flags from a signed add that overflows (N=1, V=1) and from a subtract that goes negative without overflow (N=1, V=0), evaluating both signed codes after each load. The shift-carry corners also need specific stimulus: amounts of exactly 0, 8 and 9 are applied so that the last-bit-out rule is exercised where it meets the zero-result rule.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_SHL, OP_SHR,
    OP_AND, OP_ORR, OP_EOR, OP_ZERO, OP_PASS
  } aluOp_e;

  // strobes from decode to the datapath
  typedef struct packed {
    aluOp_e op;
    logic   immArith;   // second operand = zero-extended constant
    logic   immMask;    // second operand = one-hot mask of constant
  } aluStrobe_t;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
    logic v;
  } aluFlags_t;

  localparam logic [1:0] GRP_ARITH = 2'b10;
  localparam logic [1:0] GRP_LOGIC = 2'b11;

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 4
) (
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output aluFlags_t         nextFlags
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] maskVec;
  logic [DATA_W-1:0] bArith;
  logic [DATA_W-1:0] bLogic;
  logic [DATA_W:0]   wide;
  logic [DATA_W-1:0] res;
  logic              carry;
  logic              ovf;

  assign immExt = DATA_W'(imm);

  // one-hot mask: bit k lit when the constant equals k
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < (1 << IMM_W)) begin : g_reach
      assign maskVec[i] = (imm == IMM_W'(i));
    end else begin : g_unreach
      assign maskVec[i] = 1'b0;
    end
  end

  assign bArith = strobe.immArith ? immExt  : opB;
  assign bLogic = strobe.immMask  ? maskVec : opB;

  always_comb begin
    wide  = '0;
    res   = '0;
    carry = 1'b0;
    ovf   = 1'b0;
    unique case (strobe.op)
      OP_ADD: begin
        wide  = {1'b0, opA} + {1'b0, bArith};
        res   = wide[MSB:0];
        carry = wide[DATA_W];
        ovf   = (opA[MSB] == bArith[MSB]) && (res[MSB] != opA[MSB]);
      end
      OP_SUB: begin
        wide  = {1'b0, opA} - {1'b0, bArith};
        res   = wide[MSB:0];
        carry = ~wide[DATA_W];
        ovf   = (opA[MSB] != bArith[MSB]) && (res[MSB] != opA[MSB]);
      end
      OP_SHL: begin
        wide  = {1'b0, opA} << bArith;
        res   = wide[MSB:0];
        carry = wide[DATA_W];
      end
      OP_SHR: begin
        wide  = {opA, 1'b0} >> bArith;
        res   = wide[DATA_W:1];
        carry = wide[0];
      end
      OP_AND:  res = opA & bLogic;
      OP_ORR:  res = opA | bLogic;
      OP_EOR:  res = opA ^ bLogic;
      OP_ZERO: res = '0;
      default: res = opB;
    endcase
  end

  assign result      = res;
  assign nextFlags.z = (res == '0);
  assign nextFlags.c = carry;
  assign nextFlags.n = res[MSB];
  assign nextFlags.v = ovf;

endmodule

// File: rtl/alu_control.sv
module alu_control
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        grp,
  input  logic [1:0]        op,
  input  logic              immMode,
  input  logic              flagWe,
  input  logic [3:0]        cond,
  input  aluFlags_t         nextFlags,
  input  logic [DATA_W-1:0] aluResult,
  output aluStrobe_t        strobe,
  output aluFlags_t         flagQ,
  output logic              condMet
);

  // decode group/op into datapath strobes
  always_comb begin
    strobe.op       = OP_PASS;
    strobe.immArith = 1'b0;
    strobe.immMask  = 1'b0;
    if (grp == GRP_ARITH) begin
      strobe.immArith = immMode;
      unique case (op)
        2'b00:   strobe.op = OP_ADD;
        2'b01:   strobe.op = OP_SUB;
        2'b10:   strobe.op = OP_SHL;
        default: strobe.op = OP_SHR;
      endcase
    end else if (grp == GRP_LOGIC) begin
      strobe.immMask = immMode;
      unique case (op)
        2'b00:   strobe.op = OP_AND;
        2'b01:   strobe.op = OP_ORR;
        2'b10:   strobe.op = OP_EOR;
        default: strobe.op = OP_ZERO;
      endcase
    end
  end

  // flag register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       flagQ <= '0;
    else if (flagWe) flagQ <= nextFlags;
  end

  // branch condition against stored flags
  always_comb begin
    unique case (cond)
      4'd0:    condMet = 1'b1;
      4'd1:    condMet = flagQ.z;
      4'd2:    condMet = ~flagQ.z;
      4'd3:    condMet = flagQ.c;
      4'd4:    condMet = ~flagQ.c;
      4'd5:    condMet = flagQ.n ^ flagQ.v;
      4'd6:    condMet = ~(flagQ.n ^ flagQ.v);
      default: condMet = 1'b0;
    endcase
  end

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !flagWe |=> $stable(flagQ));

  p_flag_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    flagWe |=> flagQ == $past(nextFlags));

  p_no_ovf_other_r9: assert property (@(posedge clk) disable iff (!rstN)
    (grp != GRP_ARITH || op[1]) |-> !nextFlags.v);

  p_mask_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    (grp == GRP_LOGIC && op == 2'b00 && immMode) |-> $countones(aluResult) <= 1);

  p_unused_cond_r13: assert property (@(posedge clk) disable iff (!rstN)
    (cond > 4'd6) |-> !condMet);

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        grp,
  input  logic [1:0]        op,
  input  logic              immMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic              flagWe,
  input  logic [3:0]        cond,
  output logic [DATA_W-1:0] result,
  output logic              nextZ,
  output logic              nextC,
  output logic              nextN,
  output logic              nextV,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagN,
  output logic              flagV,
  output logic              condMet
);

  aluStrobe_t strobe;
  aluFlags_t  nextFlags;
  aluFlags_t  flagQ;

  alu_control #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .grp       (grp),
    .op        (op),
    .immMode   (immMode),
    .flagWe    (flagWe),
    .cond      (cond),
    .nextFlags (nextFlags),
    .aluResult (result),
    .strobe    (strobe),
    .flagQ     (flagQ),
    .condMet   (condMet)
  );

  alu_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .imm       (imm),
    .result    (result),
    .nextFlags (nextFlags)
  );

  assign nextZ = nextFlags.z;
  assign nextC = nextFlags.c;
  assign nextN = nextFlags.n;
  assign nextV = nextFlags.v;
  assign flagZ = flagQ.z;
  assign flagC = flagQ.c;
  assign flagN = flagQ.n;
  assign flagV = flagQ.v;

endmodule

// File: tb/alu_flags_unit_tb.sv
module alu_flags_unit_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] grp = '0;
  logic [1:0] op = '0;
  logic       immMode = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [3:0] imm = '0;
  logic       flagWe = 1'b0;
  logic [3:0] cond = '0;
  logic [7:0] result;
  logic       nextZ, nextC, nextN, nextV;
  logic       flagZ, flagC, flagN, flagV;
  logic       condMet;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  alu_flags_unit u_dut (
    .clk(clk), .rstN(rstN), .grp(grp), .op(op), .immMode(immMode),
    .opA(opA), .opB(opB), .imm(imm), .flagWe(flagWe), .cond(cond),
    .result(result), .nextZ(nextZ), .nextC(nextC), .nextN(nextN),
    .nextV(nextV), .flagZ(flagZ), .flagC(flagC), .flagN(flagN),
    .flagV(flagV), .condMet(condMet)
  );

  // {grp, op, immMode, opA, opB, imm, expResult, expZCNV}
  localparam int NVEC = 25;
  localparam logic [36:0] VEC [NVEC] = '{
    {2'b10, 2'b00, 1'b0, 8'h7F, 8'h01, 4'h0, 8'h80, 4'b0011}, // R7 add overflow
    {2'b10, 2'b00, 1'b0, 8'hFF, 8'h01, 4'h0, 8'h00, 4'b1100}, // R7 add carry
    {2'b10, 2'b01, 1'b0, 8'h05, 8'h07, 4'h0, 8'hFE, 4'b0010}, // R7 sub borrow
    {2'b10, 2'b01, 1'b0, 8'h80, 8'h01, 4'h0, 8'h7F, 4'b0101}, // R7 sub overflow
    {2'b10, 2'b01, 1'b0, 8'h33, 8'h33, 4'h0, 8'h00, 4'b1100}, // R6 sub zero
    {2'b10, 2'b10, 1'b0, 8'h81, 8'h01, 4'h0, 8'h02, 4'b0100}, // R8 shl 1
    {2'b10, 2'b11, 1'b0, 8'h81, 8'h01, 4'h0, 8'h40, 4'b0100}, // R8 shr 1
    {2'b10, 2'b10, 1'b0, 8'h81, 8'h08, 4'h0, 8'h00, 4'b1100}, // R8 shl 8
    {2'b10, 2'b11, 1'b0, 8'h81, 8'h09, 4'h0, 8'h00, 4'b1000}, // R8 shr 9
    {2'b10, 2'b10, 1'b0, 8'h81, 8'h00, 4'h0, 8'h81, 4'b0010}, // R8 shl 0
    {2'b10, 2'b00, 1'b1, 8'h10, 8'hEE, 4'hF, 8'h1F, 4'b0000}, // R3 add imm
    {2'b10, 2'b01, 1'b1, 8'h03, 8'hEE, 4'h4, 8'hFF, 4'b0010}, // R3 sub imm
    {2'b10, 2'b11, 1'b1, 8'hF0, 8'h01, 4'h4, 8'h0F, 4'b0000}, // R3 shr imm
    {2'b11, 2'b00, 1'b0, 8'hF0, 8'h3C, 4'h0, 8'h30, 4'b0000}, // R2 and
    {2'b11, 2'b01, 1'b0, 8'h80, 8'h01, 4'h0, 8'h81, 4'b0010}, // R2 orr
    {2'b11, 2'b10, 1'b0, 8'h5A, 8'h5A, 4'h0, 8'h00, 4'b1000}, // R2 eor
    {2'b11, 2'b11, 1'b0, 8'hFF, 8'hFF, 4'h0, 8'h00, 4'b1000}, // R2 op11
    {2'b11, 2'b00, 1'b1, 8'h24, 8'hFF, 4'h2, 8'h04, 4'b0000}, // R4 and mask hit
    {2'b11, 2'b00, 1'b1, 8'h24, 8'hFF, 4'h3, 8'h00, 4'b1000}, // R4 and mask miss
    {2'b11, 2'b01, 1'b1, 8'h00, 8'h00, 4'h7, 8'h80, 4'b0010}, // R4 orr bit7
    {2'b11, 2'b10, 1'b1, 8'hFF, 8'h00, 4'h0, 8'hFE, 4'b0010}, // R4 eor bit0
    {2'b11, 2'b01, 1'b1, 8'h11, 8'hFF, 4'h9, 8'h11, 4'b0000}, // R4 mask zero
    {2'b00, 2'b10, 1'b0, 8'h12, 8'h00, 4'h0, 8'h00, 4'b1000}, // R5 pass zero
    {2'b01, 2'b01, 1'b1, 8'h12, 8'h9C, 4'h0, 8'h9C, 4'b0010}, // R5 pass neg
    {2'b10, 2'b11, 1'b0, 8'h80, 8'h08, 4'h0, 8'h00, 4'b1100}  // R8 shr 8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setOp(input logic [1:0] g, input logic [1:0] o, input logic im,
                       input logic [7:0] a, input logic [7:0] b, input logic [3:0] k);
    grp = g; op = o; immMode = im; opA = a; opB = b; imm = k;
  endtask

  // drive at negedge, flags captured at the next posedge
  task automatic loadFlags(input logic [1:0] g, input logic [1:0] o,
                           input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    setOp(g, o, 1'b0, a, b, 4'h0);
    flagWe = 1'b1;
    @(negedge clk);
    flagWe = 1'b0;
  endtask

  task automatic chkCond(input string req, input logic [3:0] c, input logic exp);
    cond = c;
    #1;
    chk(req, {31'd0, condMet}, {31'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // reset state (R10)
    #1;
    chk("R10 reset flags", {28'd0, flagZ, flagC, flagN, flagV}, 32'h0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    chkCond("R11 always", 4'd0, 1'b1);
    chkCond("R11 z set after reset", 4'd1, 1'b0);

    // table walk: combinational result and next flags
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      setOp(VEC[i][36:35], VEC[i][34:33], VEC[i][32], VEC[i][31:24],
            VEC[i][23:16], VEC[i][15:12]);
      #1;
      chk($sformatf("R1/R6 vec%0d result", i), {24'd0, result}, {24'd0, VEC[i][11:4]});
      chk($sformatf("R6/R9 vec%0d flags", i), {28'd0, nextZ, nextC, nextN, nextV},
          {28'd0, VEC[i][3:0]});
    end
    // writes were disabled during the walk
    chk("R10 held through table", {28'd0, flagZ, flagC, flagN, flagV}, 32'h0);

    // Z=1 C=1
    loadFlags(2'b10, 2'b00, 8'hFF, 8'h01);
    chk("R10 load", {28'd0, flagZ, flagC, flagN, flagV}, 32'hC);
    chkCond("R11 z set", 4'd1, 1'b1);
    chkCond("R11 z clear", 4'd2, 1'b0);
    chkCond("R11 c set", 4'd3, 1'b1);
    chkCond("R11 c clear", 4'd4, 1'b0);
    for (int c = 7; c < 16; c++) chkCond("R13 unused code", 4'(c), 1'b0);

    // hold when write strobe low
    @(negedge clk);
    setOp(2'b10, 2'b00, 1'b0, 8'h7F, 8'h01, 4'h0);
    @(negedge clk);
    chk("R10 hold", {28'd0, flagZ, flagC, flagN, flagV}, 32'hC);

    // N=1 V=1
    loadFlags(2'b10, 2'b00, 8'h7F, 8'h01);
    chk("R10 load nv", {28'd0, flagZ, flagC, flagN, flagV}, 32'h3);
    chkCond("R12 lt with N=V", 4'd5, 1'b0);
    chkCond("R12 ge with N=V", 4'd6, 1'b1);
    chkCond("R11 z clear", 4'd2, 1'b1);
    chkCond("R11 c clear", 4'd4, 1'b1);

    // N=1 V=0
    loadFlags(2'b10, 2'b01, 8'h05, 8'h07);
    chkCond("R12 lt with N!=V", 4'd5, 1'b1);
    chkCond("R12 ge with N!=V", 4'd6, 1'b0);
    for (int c = 7; c < 16; c++) chkCond("R13 unused code", 4'(c), 1'b0);

    // N=0 V=1
    loadFlags(2'b10, 2'b01, 8'h80, 8'h01);
    chkCond("R12 lt with V only", 4'd5, 1'b1);
    chkCond("R12 ge with V only", 4'd6, 1'b0);

    // a move clears C and V in the stored flags (R5)
    loadFlags(2'b00, 2'b10, 8'h00, 8'h00);
    chk("R5 move flags", {28'd0, flagZ, flagC, flagN, flagV}, 32'h8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule